// File: doc/BRIEF.md
# Polled Serial Channel with Register Bank

This block is one asynchronous serial channel behind a small byte-addressed register bank. Software writes a character into the transmit data byte, and the channel sends it as a framed serial character on `txd`. A character arriving on `rxd` is deserialised into the receive data byte, and a status flag tells software that it is waiting. A receive interrupt request can be enabled so that software does not have to poll.

The channel has no bit-rate generator of its own. A separate timer supplies `baud_tick`, a one-cycle enable pulse at eight times the bit rate, and both shifters count these pulses.

The register port is a plain single-cycle access with no back-pressure. Every cycle in which `bus_valid` is high is accepted. A read returns its data on `bus_rdata` one cycle later. A transmit write that arrives while the transmitter is busy is dropped, so software must poll the busy flag before each write.

Top module: `sio_channel`

## Requirements
- R1: After reset, control, interrupt control and status all read 0, `txd` is high and `irq_rx` is low.
- R2: Registers are decoded at these offsets: control at 0x0 (16 bits), interrupt control at 0x4 (8 bits, upper bits read 0), transmit data at 0x8, receive data at 0x9, and status at 0xC (16 bits). Read data appears on `bus_rdata` in the cycle after the read is accepted.
- R3: Consider a write to 0x8 while control bit 15 (transmit enable) is set and the transmitter is idle. The channel sends a low start bit, then the 8 data bits least significant bit first, then a high stop bit. Each bit lasts 8 `baud_tick` pulses.
- R4: Status bit 5 is 1 from the cycle after an accepted transmit write until the stop bit ends. A transmit write made while this bit is 1 is ignored.
- R5: While control bit 15 is clear, writes to 0x8 are ignored: `txd` stays high and status bit 5 stays 0.
- R6: While control bit 14 (receive enable) is set, the receiver works as follows. A falling edge on `rxd` starts a character. The start bit is confirmed at the 4th tick. Each data bit is then sampled 8 ticks after the previous sample, least significant bit first. A high stop bit loads the byte into the receive data register and sets status bit 4.
- R7: If `rxd` is high again at the 4th tick after a falling edge, the edge is treated as a glitch and no character is received.
- R8: Reading 0x9 clears status bit 4 and status bit 3, and drops `irq_rx`.
- R9: `irq_rx` is high exactly when status bit 4 is set and interrupt control bit 0 is set. Writing 0x11 to interrupt control enables it, and writing 0x00 disables it.
- R10: A character that completes while status bit 4 is already set replaces the held byte and sets overrun status bit 3.
- R11: While control bit 14 is clear, activity on `rxd` is ignored and status bit 4 stays 0.
- R12: A character whose stop bit is sampled low is discarded, and status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| baud_tick | input | 1 | Enable pulse at 8x the bit rate |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The in-line assertions check the following on every cycle:
- an accepted transmit write raises busy and drives the start bit in the next cycle;
- `txd` changes only after a tick;
- a receive-data read clears the ready flag;
- overrun can appear only on top of a ready flag;
- the receiver's byte strobe lasts a single cycle.

Only the bench scenarios can show the following:
- the bit order and timing of whole frames;
- glitch rejection and framing-error discard;
- interrupt gating by the enable bit;
- the ignored writes while busy or disabled;
- the byte replacement on overrun.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_IEN  = 4'h4;
  localparam logic [3:0] OFS_TXB  = 4'h8;
  localparam logic [3:0] OFS_RXB  = 4'h9;
  localparam logic [3:0] OFS_STAT = 4'hC;

  localparam int CTRL_TX_ON  = 15;
  localparam int CTRL_RX_ON  = 14;
  localparam int IEN_RX      = 0;
  localparam int STAT_BUSY   = 5;
  localparam int STAT_READY  = 4;
  localparam int STAT_OVRUN  = 3;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CW      = $clog2(OVS);
  localparam int BW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame;
  logic [CW-1:0]      tcnt;
  logic [BW-1:0]      bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
      busy  <= 1'b0;
    end else if (load && !busy) begin
      frame <= {1'b1, din, 1'b0};
      tcnt  <= '0;
      bcnt  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt  <= '0;
        frame <= {1'b1, frame[FRAME_W-1:1]};
        if (bcnt == BW'(FRAME_W - 1)) busy <= 1'b0;
        else                          bcnt <= bcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd = frame[0];

  // R3, R4: an accepted load starts the frame with a low start bit
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> (busy && !txd));

  // R3: the line only moves after a tick while a frame is in flight
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(txd));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_out
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_W);
  localparam int HALF = OVS / 2;

  logic       s1, s2, s3;
  rx_state_t  state;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DATA_W-1:0] shreg;
  logic fall;

  assign fall = s3 && !s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: if (fall) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tick) begin
            if (tcnt == CW'(HALF - 1)) begin
              tcnt  <= '0;
              bcnt  <= '0;
              state <= s2 ? RX_IDLE : RX_BITS;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_BITS: if (tick) begin
            if (tcnt == CW'(OVS - 1)) begin
              tcnt  <= '0;
              shreg <= {s2, shreg[DATA_W-1:1]};
              if (bcnt == BW'(DATA_W - 1)) state <= RX_STOP;
              else                         bcnt  <= bcnt + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_STOP: if (tick) begin
            if (tcnt == CW'(OVS - 1)) begin
              tcnt       <= '0;
              state      <= RX_IDLE;
              byte_valid <= s2;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_out = shreg;

  // R6: a completed character is announced for one cycle only
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tx_busy,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              irq
);
  logic [REG_W-1:0]  ctrl;
  logic [7:0]        ien;
  logic [DATA_W-1:0] rx_hold;
  logic              rx_ready, overrun;
  logic              wr, rd, rd_rx;
  logic [REG_W-1:0]  stat;

  assign wr    = bus_valid && bus_write;
  assign rd    = bus_valid && !bus_write;
  assign rd_rx = rd && (bus_addr == ADDR_W'(OFS_RXB));

  assign tx_load = wr && (bus_addr == ADDR_W'(OFS_TXB)) && ctrl[CTRL_TX_ON];
  assign tx_data = bus_wdata[DATA_W-1:0];
  assign rx_en   = ctrl[CTRL_RX_ON];
  assign irq     = rx_ready && ien[IEN_RX];

  always_comb begin
    stat             = '0;
    stat[STAT_BUSY]  = tx_busy;
    stat[STAT_READY] = rx_ready;
    stat[STAT_OVRUN] = overrun;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      ien  <= '0;
    end else if (wr) begin
      if (bus_addr == ADDR_W'(OFS_CTRL)) ctrl <= bus_wdata;
      if (bus_addr == ADDR_W'(OFS_IEN))  ien  <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else if (rx_valid) begin
      rx_hold  <= rx_byte;
      rx_ready <= 1'b1;
      overrun  <= rx_ready && !rd_rx;
    end else if (rd_rx) begin
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd) begin
      unique case (bus_addr)
        ADDR_W'(OFS_CTRL): bus_rdata <= ctrl;
        ADDR_W'(OFS_IEN):  bus_rdata <= REG_W'(ien);
        ADDR_W'(OFS_RXB):  bus_rdata <= REG_W'(rx_hold);
        ADDR_W'(OFS_STAT): bus_rdata <= stat;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  // R8: reading the receive byte empties the holding flag
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_valid) |=> !rx_ready);

  // R10: overrun can only rise on top of an unread byte
  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));
endmodule

// File: rtl/sio_channel.sv
module sio_channel
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_rx
);
  logic              tx_busy, tx_load, rx_en, rx_valid;
  logic [DATA_W-1:0] tx_data, rx_byte;

  sio_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_data(tx_data),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .irq(irq_rx)
  );

  sio_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .load(tx_load), .din(tx_data), .busy(tx_busy), .txd(txd)
  );

  sio_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_en),
    .rxd(rxd), .byte_valid(rx_valid), .byte_out(rx_byte)
  );
endmodule

// File: tb/sio_channel_test.sv
module sio_channel_test;
  localparam int BIT_CLKS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        baud_tick = 1'b0;
  logic        rxd = 1'b1;
  logic        txd;
  logic        irq_rx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sio_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .irq_rx(irq_rx)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = cnt + 1;
      baud_tick = (cnt % 4 == 0);
    end
  end

  // each entry: {byte to transmit, byte to receive}
  localparam logic [15:0] VEC [4] = '{16'h55A3, 16'h00FF, 16'hFF00, 16'hC381};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv);
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stopv;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // captures one frame from txd, assumed already started or about to
  task automatic grab_tx(input string req, input logic [7:0] exp);
    logic [7:0] got;
    logic st, sp;
    int guard = 0;
    while (txd === 1'b1 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (16) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      got[i] = txd;
    end
    repeat (BIT_CLKS) @(negedge clk);
    sp = txd;
    chk(req, {7'b0, st, got}, {7'b0, 1'b0, exp});
    chk(req, {15'b0, sp}, 16'h0001);
  endtask

  task automatic line_quiet(input string req, input int n);
    logic seen_low = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    chk(req, {15'b0, seen_low}, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (R1..R12 run hung): actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd", {15'b0, txd}, 16'h0001);
    chk("R1 irq", {15'b0, irq_rx}, 16'h0000);
    bus_rd(4'h0, d); chk("R1 ctrl", d, 16'h0000);
    bus_rd(4'h4, d); chk("R1 ien", d, 16'h0000);
    bus_rd(4'hC, d); chk("R1 status", d, 16'h0000);

    // R2 decode and readback
    bus_wr(4'h0, 16'hC085);
    bus_wr(4'h4, 16'hFF11);
    bus_rd(4'h0, d); chk("R2 ctrl readback", d, 16'hC085);
    bus_rd(4'h4, d); chk("R2 ien readback", d, 16'h0011);
    bus_wr(4'h4, 16'h0000);

    // table walk: R3 transmit frames, R6 receive frames
    for (int k = 0; k < 4; k++) begin
      bus_wr(4'h8, {8'h00, VEC[k][15:8]});
      grab_tx("R3 frame", VEC[k][15:8]);
      repeat (40) @(negedge clk);
      send_rx(VEC[k][7:0], 1'b1);
      bus_rd(4'hC, d); chk("R6 ready", d, 16'h0010);
      bus_rd(4'h9, d); chk("R6 data", d, {8'h00, VEC[k][7:0]});
      bus_rd(4'hC, d); chk("R8 cleared", d, 16'h0000);
    end

    // R4 busy flag and ignored write while busy
    bus_wr(4'h8, 16'h00A5);
    bus_rd(4'hC, d); chk("R4 busy set", d, 16'h0020);
    bus_wr(4'h8, 16'h003C);
    grab_tx("R4 first byte kept", 8'hA5);
    repeat (40) @(negedge clk);
    bus_rd(4'hC, d); chk("R4 busy clear", d, 16'h0000);
    line_quiet("R4 second write dropped", 400);

    // R7 glitch on the line
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    bus_rd(4'hC, d); chk("R7 glitch rejected", d, 16'h0000);

    // R12 framing error
    send_rx(8'h5A, 1'b0);
    bus_rd(4'hC, d); chk("R12 bad stop dropped", d, 16'h0000);

    // R10 overrun
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    bus_rd(4'hC, d); chk("R10 overrun status", d, 16'h0018);
    bus_rd(4'h9, d); chk("R10 newest byte", d, 16'h0022);
    bus_rd(4'hC, d); chk("R8 overrun cleared", d, 16'h0000);

    // R9 interrupt gating
    bus_wr(4'h4, 16'h0011);
    send_rx(8'h7E, 1'b1);
    chk("R9 irq raised", {15'b0, irq_rx}, 16'h0001);
    bus_rd(4'h9, d);
    chk("R8 irq dropped", {15'b0, irq_rx}, 16'h0000);
    bus_wr(4'h4, 16'h0000);
    send_rx(8'h7E, 1'b1);
    chk("R9 irq masked", {15'b0, irq_rx}, 16'h0000);
    bus_rd(4'hC, d); chk("R9 ready while masked", d, 16'h0010);
    bus_rd(4'h9, d);

    // R11 receiver disabled
    bus_wr(4'h0, 16'h8000);
    send_rx(8'h99, 1'b1);
    bus_rd(4'hC, d); chk("R11 rx ignored", d, 16'h0000);

    // R5 transmitter disabled
    bus_wr(4'h0, 16'h4000);
    bus_wr(4'h8, 16'h0012);
    bus_rd(4'hC, d); chk("R5 no busy", d, 16'h0000);
    line_quiet("R5 line idle", 400);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule